// File: doc/BRIEF.md
# SD Host Command Issuer

This block drives the single-bit command line of an SD/MMC host, one command at a time. Software first loads a 32-bit argument. It then writes a control word that holds the leading frame byte, a launch bit, a response-expected bit and a long-response bit. The launch bit is not stored. Writing it while the block is idle starts the command. The block shifts out a 48-bit frame, most significant bit first. The frame ends with a CRC7 and a stop bit of 1.

When a response is requested, the block releases the line and waits for the card's start bit. It then shifts in either a 48-bit or a 136-bit response. For the short form it checks the CRC7. Completion, timeout and CRC trouble are reported as sticky flags, which software clears by writing ones. A busy output stays high from launch until the command is finished.

Top module: `sdcmd_issuer`

## Requirements
- R1: After reset, busy is 0, cmd_oe is 0, cmd_out is 1 and all four flags are 0.
- R2: Writes use wr_sel: 0 = argument, 1 = control, 2 = flag clear. In the control word, bits [7:0] are the leading frame byte, bit 8 launches, bit 9 requests a response and bit 10 selects the long response. A control write with bit 8 set while idle raises busy and cmd_oe on the next cycle. A control write with bit 8 clear starts nothing.
- R3: While cmd_oe is high, for exactly 48 cycles, cmd_out carries these fields, MSB first: control[7:0], then the 32-bit argument, then CRC7, then a 1. The CRC7 uses the generator x^7+x^3+1 with a zero start value and covers the first 40 bits.
- R4: Without a response request, cmd_oe and busy both drop after the last bit, and flag bit 0 (sent) is set.
- R5: For a short response, the block captures 48 bits, counting from the card's 0 start bit. Busy then drops and flag bit 1 (response end) is set. rsp_idx takes response bits [45:40]. rsp_body holds response bits [39:8], zero-extended.
- R6: For a long response, the block captures 136 bits. It then sets flag bit 1. rsp_idx takes bits [133:128] and rsp_body takes bits [127:0]. No CRC check is made.
- R7: The card's start bit is accepted in any of the first RSP_WAIT cycles after cmd_oe drops. If none arrives, busy drops and flag bit 2 (timeout) is set.
- R8: If a short response's bits [7:1] differ from the CRC7 of its bits [47:8], flag bit 3 is set together with flag bit 1.
- R9: A write with wr_sel 2 clears each flag whose wr_data bit is 1 and leaves the other flags unchanged.
- R10: While busy, argument and control writes are ignored. The frame being sent does not change, and the stored argument keeps its old value.
- R11: Busy stays high without a gap from launch until completion, and cmd_oe is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the command line advances one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 argument, 1 control, 2 flag clear |
| wr_data | input | 32 | Write data |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Command line drive value (1 when not driving) |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | Command in progress |
| flags | output | 4 | Sticky flags: 0 sent, 1 response end, 2 timeout, 3 CRC error |
| rsp_idx | output | 6 | Index field of the last response |
| rsp_body | output | 128 | Payload of the last response |

## Verification
The bench builds the block with RSP_WAIT set to 8 instead of 64. This keeps every possible start-bit delay within reach in a short run, including the last accepted cycle and the first timed-out one. With that setting, every 6-bit index value is swept, each with its own argument pattern. The sweep rotates through four cases: no response, short response, long response, and short response with a corrupted CRC. A walking-one argument sweep then exercises every argument bit position through the CRC.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} cmd_state_t;

  localparam logic [1:0] SEL_ARG  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  localparam int CTL_LAUNCH = 8;
  localparam int CTL_RESP   = 9;
  localparam int CTL_LONG   = 10;

  localparam int FLAG_SENT = 0;
  localparam int FLAG_RSP  = 1;
  localparam int FLAG_TOUT = 2;
  localparam int FLAG_CRC  = 3;
  localparam int N_FLAGS   = 4;

  localparam int CRC_SPAN = 40;

  // One serial step of the x^7 + x^3 + 1 generator.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

  // CRC7 over a 40-bit span, fed MSB first.
  function automatic logic [6:0] crc7_of(input logic [CRC_SPAN-1:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx #(
  parameter int N = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [N-1:0] frame,
  output logic         bit_out,
  output logic         last
);
  localparam int CW = $clog2(N);

  logic [N-1:0]  sr;
  logic [CW-1:0] cnt;

  assign bit_out = sr[N-1];
  assign last    = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '1;
      cnt <= '0;
    end else if (load) begin
      sr  <= frame;
      cnt <= CW'(N - 1);
    end else if (shift && !last) begin
      sr  <= {sr[N-2:0], 1'b1};
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int SHORT_N = 48,
  parameter int LONG_N  = 136,
  parameter int BODY_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first,
  input  logic              shift,
  input  logic              bit_in,
  input  logic              long_sel,
  output logic              done,
  output logic              crc_bad,
  output logic [5:0]        idx,
  output logic [BODY_W-1:0] body
);
  localparam int CW = $clog2(LONG_N + 1);
  localparam int KEEP = LONG_N - 2;

  logic [KEEP-2:0] sr;
  logic [KEEP-1:0] nxt;
  logic [CW-1:0]   remain;
  logic            long_q;

  assign nxt     = {sr, bit_in};
  assign done    = shift && (remain == CW'(1));
  assign crc_bad = done && !long_q &&
                   (crc7_of(nxt[SHORT_N-1 -: CRC_SPAN]) != nxt[7:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      remain <= '0;
      long_q <= 1'b0;
      idx    <= '0;
      body   <= '0;
    end else if (first) begin
      sr     <= {{(KEEP-2){1'b0}}, bit_in};
      remain <= long_sel ? CW'(LONG_N - 1) : CW'(SHORT_N - 1);
      long_q <= long_sel;
    end else if (shift) begin
      sr     <= nxt[KEEP-2:0];
      remain <= remain - CW'(1);
      if (done) begin
        if (long_q) begin
          idx  <= nxt[LONG_N-3 -: 6];
          body <= nxt[BODY_W-1:0];
        end else begin
          idx  <= nxt[SHORT_N-3 -: 6];
          body <= BODY_W'(nxt[SHORT_N-9 -: 32]);
        end
      end
    end
  end
endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int RSP_WAIT   = 64,
  parameter int FRAME_BITS = 48,
  parameter int LONG_BITS  = 136,
  parameter int BODY_W     = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               cmd_in,
  output logic               cmd_out,
  output logic               cmd_oe,
  output logic               busy,
  output logic [N_FLAGS-1:0] flags,
  output logic [5:0]         rsp_idx,
  output logic [BODY_W-1:0]  rsp_body
);
  localparam int WCW = $clog2(RSP_WAIT + 1);

  cmd_state_t     state;
  logic [31:0]    arg_q;
  logic           resp_q, long_q;
  logic [WCW-1:0] wcnt;

  logic [FRAME_BITS-1:0] frame_w;
  logic tx_bit, tx_last;
  logic rx_done, rx_crc_bad;

  // Named internal events for the checker
  logic ev_launch, ev_tx_done, ev_sent, ev_rsp_start, ev_timeout, ev_rsp_done;
  logic [N_FLAGS-1:0] set_v, clr_v;

  assign ev_launch    = wr_en && (wr_sel == SEL_CTRL) && (state == ST_IDLE) && wr_data[CTL_LAUNCH];
  assign ev_tx_done   = (state == ST_TX) && tx_last;
  assign ev_sent      = ev_tx_done && !resp_q;
  assign ev_rsp_start = (state == ST_WAIT) && !cmd_in;
  assign ev_timeout   = (state == ST_WAIT) && cmd_in && (wcnt == WCW'(RSP_WAIT - 1));
  assign ev_rsp_done  = rx_done;

  assign frame_w = {wr_data[7:0], arg_q, crc7_of({wr_data[7:0], arg_q}), 1'b1};

  sdcmd_tx #(.N(FRAME_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(ev_launch), .shift(state == ST_TX),
    .frame(frame_w), .bit_out(tx_bit), .last(tx_last)
  );

  sdcmd_rx #(.SHORT_N(FRAME_BITS), .LONG_N(LONG_BITS), .BODY_W(BODY_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .first(ev_rsp_start), .shift(state == ST_RX),
    .bit_in(cmd_in), .long_sel(long_q), .done(rx_done), .crc_bad(rx_crc_bad),
    .idx(rsp_idx), .body(rsp_body)
  );

  assign busy    = (state != ST_IDLE);
  assign cmd_oe  = (state == ST_TX);
  assign cmd_out = cmd_oe ? tx_bit : 1'b1;

  always_comb begin
    set_v            = '0;
    set_v[FLAG_SENT] = ev_sent;
    set_v[FLAG_RSP]  = ev_rsp_done;
    set_v[FLAG_TOUT] = ev_timeout;
    set_v[FLAG_CRC]  = rx_crc_bad;
    clr_v = (wr_en && wr_sel == SEL_CLR) ? wr_data[N_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      arg_q  <= '0;
      resp_q <= 1'b0;
      long_q <= 1'b0;
      wcnt   <= '0;
      flags  <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      case (state)
        ST_IDLE: begin
          if (wr_en && wr_sel == SEL_ARG) arg_q <= wr_data;
          if (ev_launch) begin
            resp_q <= wr_data[CTL_RESP];
            long_q <= wr_data[CTL_LONG];
            state  <= ST_TX;
          end
        end
        ST_TX: begin
          if (ev_tx_done) begin
            wcnt  <= '0;
            state <= resp_q ? ST_WAIT : ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (ev_rsp_start)    state <= ST_RX;
          else if (ev_timeout) state <= ST_IDLE;
          else                 wcnt  <= wcnt + WCW'(1);
        end
        ST_RX: begin
          if (rx_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_issuer_chk.sv
module sdcmd_issuer_chk #(
  parameter int FRAME_BITS = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_oe,
  input logic       busy,
  input logic [3:0] flags,
  input logic       ev_launch,
  input logic       ev_sent,
  input logic       ev_timeout,
  input logic       ev_rsp_done,
  input logic       rx_crc_bad
);
  logic [7:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oe_run <= '0;
    else if (cmd_oe) oe_run <= oe_run + 8'd1;
    else             oe_run <= '0;
  end

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> busy && cmd_oe);

  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> oe_run == 8'(FRAME_BITS));

  assert_frame_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> oe_run < 8'(FRAME_BITS));

  assert_sent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sent |=> !busy && flags[0]);

  assert_rsp_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_done |=> !busy && flags[1]);

  assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> !busy && flags[2]);

  assert_crc_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_bad |=> flags[3] && flags[1]);

  assert_oe_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  assert_single_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_sent, ev_timeout, ev_rsp_done}));
endmodule

bind sdcmd_issuer sdcmd_issuer_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .busy(busy), .flags(flags),
  .ev_launch(ev_launch), .ev_sent(ev_sent), .ev_timeout(ev_timeout),
  .ev_rsp_done(ev_rsp_done), .rx_crc_bad(rx_crc_bad)
);

// File: tb/tb_sdcmd_issuer.sv
module tb_sdcmd_issuer;
  localparam int RSP_W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_sel;
  logic [31:0]  wr_data;
  logic         cmd_in;
  logic         cmd_out, cmd_oe, busy;
  logic [3:0]   flags;
  logic [5:0]   rsp_idx;
  logic [127:0] rsp_body;

  int vecs = 0;
  int miss = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdcmd_issuer #(.RSP_WAIT(RSP_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
    .flags(flags), .rsp_idx(rsp_idx), .rsp_body(rsp_body)
  );

  // Long division by 0x89 (x^7 + x^3 + 1)
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [135:0] act, input logic [135:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic run_cmd(input logic [7:0] cb, input logic [31:0] arg, input bit arg_wr,
                         input bit wt, input bit lg, input int dly, input bit corrupt,
                         input bit inject, input bit clr, input logic [3:0] pre);
    logic [47:0]  ef, got;
    logic [135:0] rf;
    logic [3:0]   ef_flags;
    bit           cont;
    int           n;
    if (arg_wr) wr(2'd0, arg);
    wr(2'd1, {21'b0, lg, wt, 1'b1, cb});
    chk(busy && cmd_oe, "R2", "launch busy/oe", {busy, cmd_oe}, 2'b11);
    ef = {cb, arg, ref_crc({cb, arg}), 1'b1};
    cont = 1'b1;
    for (int i = 0; i < 48; i++) begin
      got[47-i] = cmd_out;
      if (!cmd_oe || !busy) cont = 1'b0;
      if (inject && i == 5) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = {21'b0, 3'b111, cb ^ 8'h15}; end
      if (inject && i == 6) begin wr_sel = 2'd0; wr_data = ~arg; end
      if (inject && i == 7) begin wr_en = 1'b0; wr_sel = 2'd3; end
      @(negedge clk);
    end
    chk(got == ef, inject ? "R10" : "R3", "frame", got, ef);
    chk(cont && !cmd_oe, "R11", "oe window", {cont, cmd_oe}, 2'b10);
    if (!wt) begin
      chk(!busy && flags == (pre | 4'b0001), "R4", "no-response end", {busy, flags}, {1'b0, pre | 4'b0001});
    end else if (dly >= RSP_W) begin
      repeat (RSP_W - 1) @(negedge clk);
      chk(busy, "R7", "still waiting", busy, 1'b1);
      @(negedge clk);
      chk(!busy && flags == (pre | 4'b0100), "R7", "timeout", {busy, flags}, {1'b0, pre | 4'b0100});
    end else begin
      rf = '0;
      if (lg) begin
        rf = {arg, ~arg, arg ^ 32'h0F0F_F0F0, arg + 32'h1234_5678, 8'hC3};
        rf[135:134] = 2'b00; rf[0] = 1'b1; n = 136;
      end else begin
        rf[47:8] = {2'b00, cb[5:0], ~arg};
        rf[7:1]  = ref_crc(rf[47:8]) ^ (corrupt ? 7'h01 : 7'h00);
        rf[0]    = 1'b1; n = 48;
      end
      repeat (dly) @(negedge clk);
      chk(busy, "R7", "waiting for start", busy, 1'b1);
      for (int k = 0; k < n; k++) begin
        cmd_in = rf[n-1-k];
        @(negedge clk);
      end
      cmd_in = 1'b1;
      ef_flags = pre | 4'b0010 | ((corrupt && !lg) ? 4'b1000 : 4'b0000);
      chk(!busy && flags == ef_flags, corrupt ? "R8" : (lg ? "R6" : "R5"), "response flags",
          {busy, flags}, {1'b0, ef_flags});
      if (lg) begin
        chk(rsp_idx == rf[133:128], "R6", "long idx", rsp_idx, rf[133:128]);
        chk(rsp_body == rf[127:0], "R6", "long body", rsp_body, rf[127:0]);
      end else begin
        chk(rsp_idx == rf[45:40], "R5", "short idx", rsp_idx, rf[45:40]);
        chk(rsp_body == {96'b0, rf[39:8]}, "R5", "short body", rsp_body, {96'b0, rf[39:8]});
      end
    end
    if (clr) begin
      wr(2'd2, 32'hF);
      chk(flags == 4'b0, "R9", "clear all", flags, 4'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0; cmd_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_oe && cmd_out && flags == 4'b0, "R1", "reset state",
        {busy, cmd_oe, cmd_out, flags}, 7'b0010000);

    wr(2'd1, 32'h0000_0245);
    chk(!busy && !cmd_oe, "R2", "no launch without bit 8", {busy, cmd_oe}, 2'b00);

    for (int i = 0; i < 64; i++) begin
      logic [7:0]  b;
      logic [31:0] a;
      b = 8'(i);
      a = {b * 8'd37, ~b, b ^ 8'hA5, 8'h3C + b};
      run_cmd({2'b01, b[5:0]}, a, 1'b1, (i % 4) != 0, (i % 4) == 2, i % RSP_W,
              (i % 4) == 3, 1'b0, 1'b1, 4'b0);
    end

    for (int d = 0; d <= RSP_W; d++)
      run_cmd(8'h51, 32'hC0DE_0000 + 32'(d), 1'b1, 1'b1, 1'b0, d, 1'b0, 1'b0, 1'b1, 4'b0);

    for (int k = 0; k < 32; k++)
      run_cmd(8'h40 | 8'(k), 32'h1 << k, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 4'b0);

    // R9: partial clear keeps the other flags
    run_cmd(8'h4C, 32'h0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 4'b0000);
    run_cmd(8'h4D, 32'h1, 1'b1, 1'b1, 1'b0, RSP_W, 1'b0, 1'b0, 1'b0, 4'b0001);
    wr(2'd2, 32'h1);
    chk(flags == 4'b0100, "R9", "partial clear", flags, 4'b0100);
    wr(2'd2, 32'h4);
    chk(flags == 4'b0000, "R9", "second clear", flags, 4'b0000);

    // R10: writes while busy are ignored
    run_cmd(8'h4A, 32'hA5A5_1234, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b1, 4'b0);
    run_cmd(8'h4B, 32'hA5A5_1234, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 4'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule